// File: doc/BRIEF.md
# Set/Clear-Mask Interrupt Controller

This block collects 64 interrupt request lines and tells the CPU which one to serve. Software never rewrites a whole mask word. To mask one source it writes that source's number as a byte to a set-mask port, and to unmask it writes the number to a clear-mask port. The code 0xFF masks every source in one write on the set port and unmasks every source on the clear port.

Each source also owns a byte-wide level register. These registers form a contiguous array at register addresses 0x00 to 0x3F, one per source index. A source competes for the CPU only when all three of these hold: its request is high, it is unmasked, and its level is nonzero. The winner is the pending source with the highest level, and a tie goes to the lowest index. The block reports the winner's index and level from registers.

Top module: `setclr_intc`

## Requirements
- R1: After reset all 64 mask bits read as 1, every level register reads 0x00, and `irq_valid_o` is low.
- R2: A write of value v (0..63) to the set-mask port (address 0x40) sets mask bit v and leaves every other mask bit unchanged.
- R3: A write of value v (0..63) to the clear-mask port (address 0x41) clears mask bit v and leaves every other mask bit unchanged.
- R4: A write of 0xFF to the set-mask port sets all 64 mask bits.
- R5: A write of 0xFF to the clear-mask port clears all 64 mask bits.
- R6: Values 64 to 254 written to either mask port leave the mask unchanged.
- R7: Addresses 0x00..0x3F hold the level byte of source equal to the address. The full byte reads back as written, and only bits [2:0] are used as the level.
- R8: Source i is pending exactly when `req_i[i]` is 1, mask bit i is 0, and level bits [2:0] are nonzero. `irq_valid_o` is high exactly when some source was pending.
- R9: The reported source is the pending source with the highest level. A tie goes to the lowest index. `irq_lvl_o` equals that source's level bits [2:0].
- R10: The outputs change at the clock edge that samples the inputs. Arbitration at an edge uses the mask and levels held before any register write that commits at that same edge.
- R11: Reading address 0x48+k (k=0..7) returns mask bits [8k+7:8k], with bit 0 holding source 8k. Other unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 64 | Raw request lines, bit i is source i |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 7 | Write address |
| wr_data_i | input | 8 | Write data byte |
| rd_addr_i | input | 7 | Read address (combinational read) |
| rd_data_o | output | 8 | Read data byte |
| irq_valid_o | output | 1 | A pending source was found |
| irq_idx_o | output | 6 | Index of the winning source |
| irq_lvl_o | output | 3 | Level of the winning source |

## Verification
A mask write and an arbitration decision can fall on the same clock edge. The bench provokes this with a clear-mask write for a source that is already requesting with a nonzero level. Right after that edge it expects no valid output, because the old mask still applied. One edge later it expects that source to win. Sweeps over every source number and every out-of-range code check the mask ports. Dozens of request patterns are judged against a winner that the bench computes arithmetically.

// File: rtl/setclr_intc_pkg.sv
package setclr_intc_pkg;
    localparam int ADDR_W = 7;
    localparam logic [ADDR_W-1:0] SET_ADDR    = 7'h40;
    localparam logic [ADDR_W-1:0] CLR_ADDR    = 7'h41;
    localparam logic [ADDR_W-1:0] MASK_RD_BASE = 7'h48;
    localparam logic [7:0]        ALL_CODE    = 8'hFF;
    typedef logic [7:0] reg_byte_t;
endpackage

// File: rtl/setclr_mask.sv
module setclr_mask
    import setclr_intc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_we,
    input  logic               clr_we,
    input  reg_byte_t          code,
    output logic [NUM_SRC-1:0] mask_o
);
    localparam int IDX_W = $clog2(NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
    } mstate_t;

    mstate_t st_d, st_q;
    logic    in_range;

    always_comb begin
        st_d     = st_q;
        in_range = int'(code) < NUM_SRC;
        if (set_we) begin
            if (code == ALL_CODE) st_d.mask = '1;
            else if (in_range)    st_d.mask[code[IDX_W-1:0]] = 1'b1;
        end else if (clr_we) begin
            if (code == ALL_CODE) st_d.mask = '0;
            else if (in_range)    st_d.mask[code[IDX_W-1:0]] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mask: '1};
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    assert_set_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && int'(code) < NUM_SRC) |=> mask_o[$past(code[IDX_W-1:0])]);
    assert_clr_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we && int'(code) < NUM_SRC) |=> !mask_o[$past(code[IDX_W-1:0])]);
    assert_set_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && code == ALL_CODE) |=> (&mask_o));
    assert_clr_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we && code == ALL_CODE) |=> (mask_o == '0));
    assert_ignore_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_we || clr_we) && int'(code) >= NUM_SRC && code != ALL_CODE) |=> $stable(mask_o));
endmodule

// File: rtl/setclr_levels.sv
module setclr_levels
    import setclr_intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  reg_byte_t                wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output reg_byte_t                rdata,
    output logic [NUM_SRC*LVL_W-1:0] lvl_o
);
    localparam int IDX_W = $clog2(NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0][7:0] regs;
    } lstate_t;

    lstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && int'(waddr) < NUM_SRC) st_d.regs[waddr[IDX_W-1:0]] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = (int'(raddr) < NUM_SRC) ? st_q.regs[raddr[IDX_W-1:0]] : 8'h00;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
        assign lvl_o[i*LVL_W +: LVL_W] = st_q.regs[i][LVL_W-1:0];
    end

    assert_level_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(waddr) < NUM_SRC && raddr == waddr) |=> (rdata == $past(wdata)));
endmodule

// File: rtl/setclr_arb.sv
module setclr_arb #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       req_i,
    input  logic [NUM_SRC-1:0]       mask_i,
    input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
    output logic                     valid_o,
    output logic [$clog2(NUM_SRC)-1:0] idx_o,
    output logic [LVL_W-1:0]         lvl_o
);
    localparam int IDX_W = $clog2(NUM_SRC);

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [LVL_W-1:0] lvl;
    } astate_t;

    astate_t st_d, st_q;
    logic [NUM_SRC-1:0] pend_w;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
        assign pend_w[i] = req_i[i] && !mask_i[i] && (lvl_i[i*LVL_W +: LVL_W] != '0);
    end

    always_comb begin
        st_d = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_w[i] && (!st_d.valid || lvl_i[i*LVL_W +: LVL_W] > st_d.lvl)) begin
                st_d.valid = 1'b1;
                st_d.idx   = IDX_W'(i);
                st_d.lvl   = lvl_i[i*LVL_W +: LVL_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign idx_o   = st_q.idx;
    assign lvl_o   = st_q.lvl;

    assert_winner_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((($past(pend_w) >> idx_o) & NUM_SRC'(1)) != '0));
    assert_idle_when_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend_w) == '0) |-> !valid_o);
    assert_level_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (lvl_o != '0));
endmodule

// File: rtl/setclr_intc.sv
module setclr_intc
    import setclr_intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         req_i,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [7:0]                 wr_data_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    output logic [7:0]                 rd_data_o,
    output logic                       irq_valid_o,
    output logic [$clog2(NUM_SRC)-1:0] irq_idx_o,
    output logic [LVL_W-1:0]           irq_lvl_o
);
    localparam int NBYTES = NUM_SRC / 8;
    localparam int BSEL_W = $clog2(NBYTES);

    logic                     set_we, clr_we, lvl_we;
    logic [NUM_SRC-1:0]       mask_w;
    logic [NUM_SRC*LVL_W-1:0] lvl_w;
    reg_byte_t                lvl_rd;

    always_comb begin
        set_we = wr_en_i && (wr_addr_i == SET_ADDR);
        clr_we = wr_en_i && (wr_addr_i == CLR_ADDR);
        lvl_we = wr_en_i && (int'(wr_addr_i) < NUM_SRC);
    end

    setclr_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
        .code(wr_data_i), .mask_o(mask_w)
    );

    setclr_levels #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_lvl (
        .clk(clk), .rst_n(rst_n), .we(lvl_we), .waddr(wr_addr_i),
        .wdata(wr_data_i), .raddr(rd_addr_i), .rdata(lvl_rd), .lvl_o(lvl_w)
    );

    setclr_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_w),
        .lvl_i(lvl_w), .valid_o(irq_valid_o), .idx_o(irq_idx_o), .lvl_o(irq_lvl_o)
    );

    always_comb begin
        rd_data_o = 8'h00;
        if (int'(rd_addr_i) < NUM_SRC)
            rd_data_o = lvl_rd;
        else if (rd_addr_i[ADDR_W-1:BSEL_W] == MASK_RD_BASE[ADDR_W-1:BSEL_W])
            rd_data_o = mask_w[rd_addr_i[BSEL_W-1:0]*8 +: 8];
    end
endmodule

// File: tb/sim_setclr_intc.sv
module sim_setclr_intc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] req_i = '0;
    logic        wr_en_i = 1'b0;
    logic [6:0]  wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic [6:0]  rd_addr_i = '0;
    logic [7:0]  rd_data_o;
    logic        irq_valid_o;
    logic [5:0]  irq_idx_o;
    logic [2:0]  irq_lvl_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] m_mask;
    logic [7:0]  m_lvl [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    setclr_intc u0 (.*);

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd_mask(output logic [63:0] m);
        for (int k = 0; k < 8; k++) begin
            rd_addr_i = 7'h48 + 7'(k);
            #1;
            m[k*8 +: 8] = rd_data_o;
        end
    endtask

    task automatic chk_mask(input string rq);
        logic [63:0] m;
        rd_mask(m);
        chk(rq, m, m_mask);
    endtask

    task automatic check_arb(input string rq);
        logic       ev;
        logic [5:0] ei;
        logic [2:0] el;
        ev = 0; ei = 0; el = 0;
        for (int i = 0; i < 64; i++)
            if (req_i[i] && !m_mask[i] && m_lvl[i][2:0] != 0 && (!ev || m_lvl[i][2:0] > el)) begin
                ev = 1; ei = 6'(i); el = m_lvl[i][2:0];
            end
        @(posedge clk); #1;
        chk(rq, {54'd0, irq_valid_o, irq_idx_o, irq_lvl_o}, {54'd0, ev, ev ? ei : 6'd0, ev ? el : 3'd0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] x;
        logic [63:0] m;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        m_mask = '1;
        for (int i = 0; i < 64; i++) m_lvl[i] = 8'h00;

        // R1 reset state
        chk_mask("R1 mask");
        for (int i = 0; i < 64; i++) begin
            rd_addr_i = 7'(i); #1;
            chk("R1 level", {56'd0, rd_data_o}, 64'd0);
        end
        chk("R1 valid", {63'd0, irq_valid_o}, 64'd0);
        rd_addr_i = 7'h42; #1;
        chk("R11 unmapped", {56'd0, rd_data_o}, 64'd0);

        // R5 clear all, then R2 per-source set
        wr(7'h41, 8'hFF); m_mask = '0; chk_mask("R5");
        for (int i = 0; i < 64; i++) begin
            wr(7'h40, 8'(i)); m_mask[i] = 1'b1; chk_mask("R2 R11");
            wr(7'h41, 8'(i)); m_mask[i] = 1'b0; chk_mask("R3");
        end
        // R4 set all, then R3 per-source clear
        wr(7'h40, 8'hFF); m_mask = '1; chk_mask("R4");
        for (int i = 0; i < 64; i++) begin
            wr(7'h41, 8'(i)); m_mask[i] = 1'b0; chk_mask("R3 R11");
            wr(7'h40, 8'(i)); m_mask[i] = 1'b1;
        end
        // R6 out-of-range codes on a mixed mask
        for (int i = 0; i < 64; i += 3) begin
            wr(7'h41, 8'(i)); m_mask[i] = 1'b0;
        end
        for (int v = 64; v < 255; v++) begin
            wr(7'h40, 8'(v)); wr(7'h41, 8'(v));
            if (v % 16 == 0) chk_mask("R6");
        end
        chk_mask("R6 final");

        // R7 level registers with high bits set
        for (int i = 0; i < 64; i++) begin
            m_lvl[i] = {5'(i), 3'((i * 3 + 1) % 8)};
            wr(7'(i), m_lvl[i]);
        end
        for (int i = 0; i < 64; i++) begin
            rd_addr_i = 7'(i); #1;
            chk("R7 readback", {56'd0, rd_data_o}, {56'd0, m_lvl[i]});
        end

        // R8/R9 under partial mask then fully unmasked
        x = 64'h9E3779B97F4A7C15;
        for (int p = 0; p < 80; p++) begin
            if (p == 40) begin wr(7'h41, 8'hFF); m_mask = '0; end
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            @(negedge clk);
            case (p % 4)
                0: req_i = x;
                1: req_i = x & (x >> 5) & (x >> 11);
                2: req_i = 64'd1 << x[5:0];
                default: req_i = (p % 8 == 3) ? '1 : '0;
            endcase
            check_arb("R8 R9");
        end

        // R9 tie: equal levels, lowest index wins
        wr(7'd10, 8'h06); m_lvl[10] = 8'h06;
        wr(7'd50, 8'h06); m_lvl[50] = 8'h06;
        wr(7'd7,  8'h06); m_lvl[7]  = 8'h06;
        @(negedge clk); req_i = (64'd1 << 50) | (64'd1 << 10) | (64'd1 << 7);
        check_arb("R9 tie");

        // R10 clear-mask write coinciding with arbitration
        wr(7'h40, 8'hFF); m_mask = '1;
        wr(7'd5, 8'h03); m_lvl[5] = 8'h03;
        @(negedge clk); req_i = 64'd1 << 5;
        wr_en_i = 1'b1; wr_addr_i = 7'h41; wr_data_i = 8'd5;
        @(posedge clk); #1;
        chk("R10 old mask used", {63'd0, irq_valid_o}, 64'd0);
        @(negedge clk); wr_en_i = 1'b0;
        @(posedge clk); #1;
        chk("R10 new mask", {54'd0, irq_valid_o, irq_idx_o, irq_lvl_o}, {54'd0, 1'b1, 6'd5, 3'd3});
        rd_mask(m);
        chk("R10 R3 mask", m, ~(64'd1 << 5));

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule